// File: doc/BRIEF.md
# Dual-Bus Bidirectional Storage Register

This block keeps a small word that can be loaded from either of two buses, A and B, and shown on either or both of them. Each bus side has an input vector (what the bus currently carries), an output vector and an output-enable flag, so the block stands in for a pair of tri-state pin groups without using inout nets. The surrounding logic or pad ring combines the output vector and its enable into a real bus drive.

Two active-low load enables select which bus is captured on the rising clock edge. When both are low, the two buses are merged by bitwise OR, so a 1 on either side wins. When both are high, the stored word holds. Two active-high output disables, one per bus, independently let that bus side drive the stored word or leave it floating; a floating side presents an all-zero output vector and a low enable. An active-high asynchronous clear empties the register at once and overrides every other control.

Top module: `dual_bus_reg`

## Requirements
- R1: While `clr` is 1, the stored word is 0 immediately, with no clock edge needed, so every enabled output vector reads 0.
- R2: While `clr` is 1, rising clock edges load nothing, whatever the load enables and bus inputs are; after release the word stays 0 until a load.
- R3: `oe_a` is the inverse of `dis_a`; with `dis_a` = 0, `out_a` equals the stored word, and with `dis_a` = 1, `out_a` is all zeros.
- R4: `oe_b` and `out_b` follow `dis_b` in the same way, independently of `dis_a`, so any of the four disable combinations drives the matching set of buses.
- R5: With `ld_a_n` = 0 and `ld_b_n` = 1, a rising edge stores `in_a`.
- R6: With `ld_a_n` = 1 and `ld_b_n` = 0, a rising edge stores `in_b`.
- R7: With both `ld_a_n` and `ld_b_n` at 0, a rising edge stores `in_a | in_b` bit by bit.
- R8: With both load enables at 1 and `clr` at 0, the stored word is unchanged across rising edges, while outputs keep following the disables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; loads occur on the rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| ld_a_n | input | 1 | Load from bus A, active low |
| ld_b_n | input | 1 | Load from bus B, active low |
| dis_a | input | 1 | Output disable for bus A, active high |
| dis_b | input | 1 | Output disable for bus B, active high |
| in_a | input | WIDTH (4) | Value currently on bus A |
| in_b | input | WIDTH (4) | Value currently on bus B |
| out_a | output | WIDTH (4) | Data driven toward bus A, zero when floating |
| out_b | output | WIDTH (4) | Data driven toward bus B, zero when floating |
| oe_a | output | 1 | Bus A drive enable, active high |
| oe_b | output | 1 | Bus B drive enable, active high |

## Verification
The clocked load and hold properties are switched off while `clr` is high, so they assume every clear pulse covers at least one rising clock edge; a pulse that rose and fell between two edges would empty the word unseen by them. The stimulus therefore raises `clr` in the middle of a low phase and releases it only after the following edge, and also raises load enables during that pulse. Inputs only change away from the rising edge, so captured values are never ambiguous, and random runs mix all load-enable and disable combinations, including loads from both buses at once.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    // which bus sides take part in a capture
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_A    = 2'b01,
        SEL_B    = 2'b10,
        SEL_BOTH = 2'b11
    } load_sel_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_A    = 0;
    localparam int unsigned PORT_B    = 1;

endpackage

// File: rtl/dbr_load_sel.sv
module dbr_load_sel
    import dbr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             ld_a_n,
    input  logic             ld_b_n,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output load_sel_e        sel,
    output logic [WIDTH-1:0] cap_val
);

    always_comb begin
        sel = load_sel_e'({~ld_b_n, ~ld_a_n});
        unique case (sel)
            SEL_A:    cap_val = in_a;
            SEL_B:    cap_val = in_b;
            SEL_BOTH: cap_val = in_a | in_b;   // a set bit on either side wins
            default:  cap_val = '0;
        endcase
    end

endmodule

// File: rtl/dbr_store.sv
module dbr_store
    import dbr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  load_sel_e        sel,
    input  logic [WIDTH-1:0] cap_val,
    output logic [WIDTH-1:0] val_q
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel != SEL_NONE) begin
            st_d.word = cap_val;
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_q = st_q.word;

    // R1: the word is empty whenever clear is held, sampled mid-cycle
    always @(negedge clk) begin
        if (clr) begin
            p_clear_empty_r1: assert (val_q == '0)
                else $error("clear held but stored word is %h", val_q);
        end
    end

    // R8: no selected side means the word keeps its value
    p_hold_r8: assert property (@(posedge clk) disable iff (clr)
        (sel == SEL_NONE) |=> $stable(val_q));

endmodule

// File: rtl/dbr_port.sv
module dbr_port #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             dis,
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] out,
    output logic             oe
);

    always_comb begin
        oe  = ~dis;
        out = dis ? '0 : val;
    end

endmodule

// File: rtl/dual_bus_reg.sv
module dual_bus_reg
    import dbr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ld_a_n,
    input  logic             ld_b_n,
    input  logic             dis_a,
    input  logic             dis_b,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] out_a,
    output logic [WIDTH-1:0] out_b,
    output logic             oe_a,
    output logic             oe_b
);

    load_sel_e        sel;
    logic [WIDTH-1:0] cap_val;
    logic [WIDTH-1:0] store_val;

    logic [NUM_PORTS-1:0]            dis_v;
    logic [NUM_PORTS-1:0]            oe_v;
    logic [NUM_PORTS-1:0][WIDTH-1:0] out_v;

    dbr_load_sel #(.WIDTH(WIDTH)) u_sel (
        .ld_a_n  (ld_a_n),
        .ld_b_n  (ld_b_n),
        .in_a    (in_a),
        .in_b    (in_b),
        .sel     (sel),
        .cap_val (cap_val)
    );

    dbr_store #(.WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .clr     (clr),
        .sel     (sel),
        .cap_val (cap_val),
        .val_q   (store_val)
    );

    assign dis_v[PORT_A] = dis_a;
    assign dis_v[PORT_B] = dis_b;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dbr_port #(.WIDTH(WIDTH)) u_port (
            .dis (dis_v[p]),
            .val (store_val),
            .out (out_v[p]),
            .oe  (oe_v[p])
        );
    end

    assign out_a = out_v[PORT_A];
    assign out_b = out_v[PORT_B];
    assign oe_a  = oe_v[PORT_A];
    assign oe_b  = oe_v[PORT_B];

    // R3 / R4: an enabled side shows the stored word, a floating side shows zero
    always @(negedge clk) begin
        p_drive_a_r3: assert (oe_a ? (out_a == store_val) : (out_a == '0))
            else $error("bus A drive mismatch");
        p_drive_b_r4: assert (oe_b ? (out_b == store_val) : (out_b == '0))
            else $error("bus B drive mismatch");
    end

    p_load_a_r5: assert property (@(posedge clk) disable iff (clr)
        (!ld_a_n && ld_b_n) |=> (store_val == $past(in_a)));

    p_load_b_r6: assert property (@(posedge clk) disable iff (clr)
        (ld_a_n && !ld_b_n) |=> (store_val == $past(in_b)));

    p_load_or_r7: assert property (@(posedge clk) disable iff (clr)
        (!ld_a_n && !ld_b_n) |=> (store_val == ($past(in_a) | $past(in_b))));

endmodule

// File: tb/tb_dual_bus_reg.sv
module tb_dual_bus_reg;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr = 1'b0;
    logic         ld_a_n = 1'b1, ld_b_n = 1'b1;
    logic         dis_a = 1'b1, dis_b = 1'b1;
    logic [W-1:0] in_a = '0, in_b = '0;
    logic [W-1:0] out_a, out_b;
    logic         oe_a, oe_b;

    int total = 0;
    int bad   = 0;
    int ref_word = 0;
    bit finished = 0;

    dual_bus_reg #(.WIDTH(W)) dut (
        .clk(clk), .clr(clr), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n),
        .dis_a(dis_a), .dis_b(dis_b), .in_a(in_a), .in_b(in_b),
        .out_a(out_a), .out_b(out_b), .oe_a(oe_a), .oe_b(oe_b)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare every port against the model
    task automatic check_all(input string req);
        int ea, eb;
        ea = dis_a ? 0 : ref_word;
        eb = dis_b ? 0 : ref_word;
        chk(req, int'(oe_a), int'(!dis_a));
        chk(req, int'(oe_b), int'(!dis_b));
        chk(req, int'(out_a), ea);
        chk(req, int'(out_b), eb);
    endtask

    // drive one cycle's controls after a falling edge, then check after the rising edge
    task automatic step(input string req, input bit la, input bit lb,
                        input bit da, input bit db, input int a, input int b);
        @(negedge clk); #2;
        ld_a_n = la; ld_b_n = lb; dis_a = da; dis_b = db;
        in_a = W'(a); in_b = W'(b);
        @(posedge clk);
        if (!clr && (!la || !lb))
            ref_word = ((la ? 0 : a) | (lb ? 0 : b)) & ((1 << W) - 1);
        #3;
        check_all(req);
    endtask

    // clear raised mid low phase, loads requested meanwhile, released after the edge
    task automatic mid_clear(input int a, input int b);
        @(negedge clk); #2;
        dis_a = 1'b0; dis_b = 1'b0;
        ld_a_n = 1'b0; ld_b_n = 1'b0;
        in_a = W'(a); in_b = W'(b);
        clr = 1'b1;
        #1;
        ref_word = 0;
        check_all("R1");
        @(posedge clk); #3;
        check_all("R2");
        @(negedge clk); #2;
        clr = 1'b0; ld_a_n = 1'b1; ld_b_n = 1'b1;
        #1;
        check_all("R2");
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr = 1'b1;
        #15;
        check_all("R1");              // reset state: everything floating and empty
        @(negedge clk); #2; clr = 1'b0;

        step("R5", 0, 1, 0, 1, 'hA, 'h5);
        step("R3", 1, 1, 0, 1, 'h0, 'h0);
        step("R6", 1, 0, 1, 0, 'hF, 'h6);
        step("R4", 1, 1, 1, 0, 'h3, 'h3);
        step("R7", 0, 0, 0, 0, 'h9, 'h4);
        step("R7", 0, 0, 0, 0, 'hC, 'hC);
        step("R8", 1, 1, 1, 1, 'hF, 'hF);
        step("R8", 1, 1, 0, 0, 'h0, 'h0);
        step("R4", 1, 1, 0, 1, 'h1, 'h2);
        step("R5", 0, 1, 1, 1, 'h0, 'hF);
        step("R3", 1, 1, 0, 0, 'h0, 'h0);
        mid_clear('hF, 'hF);
        step("R2", 1, 1, 0, 0, 'h7, 'h7);
        step("R6", 1, 0, 0, 0, 'hB, 'h8);

        for (int i = 0; i < 400; i++) begin
            if (($urandom % 16) == 0) begin
                mid_clear($urandom % 16, $urandom % 16);
            end else begin
                bit la, lb;
                la = 1'($urandom);
                lb = 1'($urandom);
                step((!la && !lb) ? "R7" : (!la ? "R5" : (!lb ? "R6" : "R8")),
                     la, lb, 1'($urandom), 1'($urandom),
                     int'($urandom % 16), int'($urandom % 16));
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule